// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a simple internal request port to an external 64K x 16 asynchronous static RAM. The RAM has active-low chip select, output enable and write strobe, plus one active-low enable per byte lane. A requester presents one read or write at a time, with a 16-bit word address, 16-bit write data and a 2-bit byte mask. The controller replays the request on the RAM pins as a sequence of registered strobe phases. Read data comes back with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. Each count is the ceiling of a nanosecond limit divided by the clock period parameter, so the same RTL meets the write pulse width, address and data setup, read access time and bus release window at any clock rate. The shared data bus is presented as separate output, output-enable and input vectors, for a pad-level tri-state buffer outside the block. The controller drives the bus only around the write strobe. It keeps off the bus for a release window after every read.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `sram_ce_n`, `sram_oe_n`, `sram_we_n` and both bits of `sram_be_n` are 1, `sram_dq_oe` is 0 and `rsp_valid` is 0. While `req_ready` is 1, no strobe is low and the bus is not driven.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until that request has finished, and requests presented while it is 0 have no effect on the RAM.
- R3: For a write with a non-zero mask, `sram_we_n` is low for WR_CYC consecutive cycles. WR_CYC = ceil(max(pulse width, address-to-write-end, data-to-write-end) / clock period), and is at least ceil(cycle time / period) - 2. During the strobe `sram_ce_n` is low and `sram_oe_n` is high. Mask bit 0 selects byte lane 7:0 (`sram_be_n[0]` low) and mask bit 1 selects lane 15:8 (`sram_be_n[1]` low).
- R4: Address, chip select and byte enables go active one cycle before `sram_we_n` falls. They stay constant while it is low and remain active for one cycle after it rises. The write data also stays constant while `sram_we_n` is low.
- R5: `sram_dq_oe` is 1 exactly from the cycle `sram_we_n` falls up to and including the cycle after it rises. It is never 1 while `sram_oe_n` is low.
- R6: For a read with a non-zero mask, `sram_ce_n`, `sram_oe_n` and the selected byte enables are low and `sram_we_n` is high for RD_CYC consecutive cycles, where RD_CYC = ceil(max(address access, output-enable access, cycle time) / clock period).
- R7: Read data is sampled from `sram_dq_i` on the edge that ends the access phase. `rsp_valid` is 1 for exactly the next cycle, and byte lanes not selected by the mask read as zero in `rsp_data`.
- R8: After a read access, all strobes stay high and the bus stays undriven for TURN_CYC = ceil(bus release time / clock period) cycles before `req_ready` returns. `sram_dq_oe` is never 1 within TURN_CYC cycles of `sram_oe_n` rising.
- R9: A request with mask 00 is accepted and finishes after one cycle without any strobe going low. As a read, it returns `rsp_valid` with `rsp_data` = 0. As a write, it leaves the RAM unchanged.
- R10: A write changes only the byte lanes its mask selects. The other lane of that word keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 16 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_be_n | output | 2 | RAM byte lane enables, active low |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the RAM bus |

## Verification
The following are checked on every clock:
- the quiet idle state;
- the minimum low times of the write strobe and the output enable, measured by counters;
- the bus is never driven while output enable is low or inside the release window after it rises;
- address, byte enables and data are stable across the strobe;
- the one-cycle response pulse, with zeroed unselected lanes.

Only the bench scenarios can show the following:
- that the sampled word is the right one, using a RAM model that returns garbage until the access time has elapsed;
- that byte-masked writes merge correctly;
- that requests presented while busy are ignored;
- that an empty mask touches nothing.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSET,
    S_WSTRB,
    S_WHOLD,
    S_RACC,
    S_RTURN,
    S_NOP
  } asram_state_e;

  // ceiling division for timing limits in ns over clock period in ns
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int WR_CYC   = 7,
  parameter int RD_CYC   = 7,
  parameter int TURN_CYC = 4,
  parameter int CNT_W    = 3,
  parameter int LANES    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [LANES-1:0] req_be,
  output logic         accept,
  output asram_state_e state_d,
  output logic         cap_evt,
  output logic         nop_rd_evt
);

  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  asram_state_e     state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wr_d       = wr_q;
    accept     = 1'b0;
    cap_evt    = 1'b0;
    nop_rd_evt = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          wr_d   = req_write;
          if (req_be == '0) begin
            state_d = S_NOP;
          end else if (req_write) begin
            state_d = S_WSET;
          end else begin
            state_d = S_RACC;
            cnt_d   = RD_LD;
          end
        end
      end
      S_WSET: begin
        state_d = S_WSTRB;
        cnt_d   = WR_LD;
      end
      S_WSTRB: begin
        if (cnt_q == '0) state_d = S_WHOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_WHOLD: state_d = S_IDLE;
      S_RACC: begin
        if (cnt_q == '0) begin
          cap_evt = 1'b1;
          state_d = S_RTURN;
          cnt_d   = TURN_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_RTURN: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_NOP: begin
        nop_rd_evt = !wr_q;
        state_d    = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

endmodule

// File: rtl/asram_strobe.sv
module asram_strobe
  import asram_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  asram_state_e     state_d,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic [LANES-1:0] be_q,
  output logic [AW-1:0]    sram_addr,
  output logic             sram_ce_n,
  output logic             sram_oe_n,
  output logic             sram_we_n,
  output logic [LANES-1:0] sram_be_n,
  output logic [DW-1:0]    sram_dq_o,
  output logic             sram_dq_oe
);

  logic             act_d;
  logic [LANES-1:0] be_nx;
  logic [LANES-1:0] be_n_d;

  assign act_d = (state_d == S_WSET)  || (state_d == S_WSTRB) ||
                 (state_d == S_WHOLD) || (state_d == S_RACC);
  assign be_nx = accept ? req_be : be_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n_d[g] = !(act_d && be_nx[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b1;
      be_q       <= '0;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_be_n  <= '1;
      sram_dq_oe <= 1'b0;
    end else begin
      if (accept) begin
        be_q      <= req_be;
        sram_addr <= req_addr;
        sram_dq_o <= req_wdata;
      end
      req_ready  <= (state_d == S_IDLE);
      sram_ce_n  <= !act_d;
      sram_oe_n  <= !(state_d == S_RACC);
      sram_we_n  <= !(state_d == S_WSTRB);
      sram_be_n  <= be_n_d;
      sram_dq_oe <= (state_d == S_WSTRB) || (state_d == S_WHOLD);
    end
  end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_evt,
  input  logic             nop_rd_evt,
  input  logic [LANES-1:0] be_q,
  input  logic [DW-1:0]    sram_dq_i,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);

  logic [DW-1:0] masked;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign masked[8*g +: 8] = be_q[g] ? sram_dq_i[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_evt || nop_rd_evt;
      if (cap_evt)         rsp_data <= masked;
      else if (nop_rd_evt) rsp_data <= '0;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 55,
  parameter int T_REL_NS      = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [AW-1:0]     sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DW/8-1:0]   sram_be_n,
  output logic [DW-1:0]     sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DW-1:0]     sram_dq_i
);

  localparam int LANES    = DW / 8;
  localparam int WR_CYC   = imax(imax(1, cdiv(imax(imax(T_WP_NS, T_AW_NS), T_DW_NS), CLK_PERIOD_NS)),
                                 cdiv(T_RC_NS, CLK_PERIOD_NS) - 2);
  localparam int RD_CYC   = imax(1, imax(imax(cdiv(T_AA_NS, CLK_PERIOD_NS), cdiv(T_OE_NS, CLK_PERIOD_NS)),
                                         cdiv(T_RC_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = imax(1, cdiv(T_REL_NS, CLK_PERIOD_NS));
  localparam int CNT_W    = $clog2(imax(imax(WR_CYC, RD_CYC), TURN_CYC) + 1);

  logic             accept;
  asram_state_e     state_d;
  logic             cap_evt;
  logic             nop_rd_evt;
  logic [LANES-1:0] be_q;

  asram_seq #(
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W),
    .LANES   (LANES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .accept    (accept),
    .state_d   (state_d),
    .cap_evt   (cap_evt),
    .nop_rd_evt(nop_rd_evt)
  );

  asram_strobe #(
    .AW   (AW),
    .DW   (DW),
    .LANES(LANES)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .state_d   (state_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_ready (req_ready),
    .be_q      (be_q),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_be_n (sram_be_n),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe)
  );

  asram_rdcap #(
    .DW   (DW),
    .LANES(LANES)
  ) u_rdcap (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .nop_rd_evt(nop_rd_evt),
    .be_q      (be_q),
    .sram_dq_i (sram_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WR_CYC   = 7,
  parameter int RD_CYC   = 7,
  parameter int TURN_CYC = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_data,
  input logic [AW-1:0]   sram_addr,
  input logic            sram_ce_n,
  input logic            sram_oe_n,
  input logic            sram_we_n,
  input logic [DW/8-1:0] sram_be_n,
  input logic [DW-1:0]   sram_dq_o,
  input logic            sram_dq_oe
);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_lo_cnt;
  logic [15:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      quiet_cnt <= 16'(TURN_CYC);
    end else begin
      we_lo_cnt <= sram_we_n ? 16'd0 : we_lo_cnt + 16'd1;
      oe_lo_cnt <= sram_oe_n ? 16'd0 : oe_lo_cnt + 16'd1;
      if (!sram_oe_n)                     quiet_cnt <= '0;
      else if (quiet_cnt != 16'hFFFF)     quiet_cnt <= quiet_cnt + 16'd1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_lo_cnt >= 16'(WR_CYC)));

  a_r4_setup_before_we: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> $past(!sram_ce_n));

  a_r4_stable_in_we: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && $past(!sram_we_n)) |->
      ($stable(sram_addr) && $stable(sram_be_n) && $stable(sram_dq_o)));

  a_r4_ce_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> !sram_ce_n);

  a_r5_drive_with_we: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_dq_oe && !sram_ce_n && sram_oe_n));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe);

  a_r6_oe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (oe_lo_cnt >= 16'(RD_CYC)));

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  for (genvar g = 0; g < DW/8; g++) begin : g_lane_chk
    a_r7_lane_zero: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && $past(sram_be_n[g])) |-> (rsp_data[8*g +: 8] == 8'h00));
  end

  a_r8_release_window: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (quiet_cnt >= 16'(TURN_CYC)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW      (AW),
  .DW      (DW),
  .WR_CYC  (WR_CYC),
  .RD_CYC  (RD_CYC),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_be_n (sram_be_n),
  .sram_dq_o (sram_dq_o),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int TCK = 8;

  function automatic int cd(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  localparam int EXP_WR   = cd(50, TCK);
  localparam int EXP_RD   = cd(55, TCK);
  localparam int EXP_TURN = cd(25, TCK);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_i = 16'hDEAD;

  asram_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] ram   [int];
  logic [15:0] refm  [int];

  function automatic logic [15:0] fillval(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] ram_get(input logic [15:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : fillval(a);
  endfunction

  function automatic logic [15:0] ref_get(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : fillval(a);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] sel);
    return {sel[1] ? nw[15:8] : old[15:8], sel[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lanes_only(input logic [15:0] v, input logic [1:0] sel);
    return {sel[1] ? v[15:8] : 8'h00, sel[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // RAM model, evaluated away from the active edge
  int          rcnt = 0;
  logic [15:0] raddr = '0;
  int          wlo = 0;
  logic [15:0] w_addr = '0, w_dat = '0;
  logic [1:0]  w_sel = '0;
  int          quiet = 1000;
  int          ce_cycles = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sram_dq_oe && !sram_oe_n)
        check(0, "R5 bus driven while output enable low", 32'(sram_dq_oe), 32'd0);
      if (sram_dq_oe && quiet < EXP_TURN)
        check(0, "R8 bus driven inside release window", 32'(quiet), 32'(EXP_TURN));
      if (sram_oe_n) quiet = (quiet < 1000) ? quiet + 1 : quiet;
      else           quiet = 0;
      if (!sram_ce_n) ce_cycles++;

      if (!sram_we_n) begin
        if (wlo == 0) begin
          w_addr = sram_addr; w_dat = sram_dq_o; w_sel = ~sram_be_n;
          if (!sram_dq_oe) check(0, "R5 data not driven at strobe", 32'd0, 32'd1);
        end else if (sram_addr != w_addr || sram_dq_o != w_dat || ~sram_be_n != w_sel) begin
          check(0, "R4 address/data/lanes moved during strobe", 32'(sram_addr), 32'(w_addr));
        end
        wlo++;
      end else if (wlo > 0) begin
        check(wlo >= EXP_WR, "R3 write strobe width", 32'(wlo), 32'(EXP_WR));
        check(!sram_ce_n && sram_dq_oe, "R4/R5 select and data held after strobe",
              32'({sram_ce_n, sram_dq_oe}), 32'b01);
        ram[int'(w_addr)] = merge(ram_get(w_addr), w_dat, w_sel);
        wlo = 0;
      end

      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        if (rcnt > 0 && sram_addr == raddr) rcnt++;
        else begin rcnt = 1; raddr = sram_addr; end
      end else begin
        rcnt = 0;
      end
      if (rcnt >= EXP_RD) begin
        sram_dq_i[7:0]  = !sram_be_n[0] ? ram_get(raddr)[7:0]  : 8'hE7;
        sram_dq_i[15:8] = !sram_be_n[1] ? ram_get(raddr)[15:8] : 8'hE7;
      end else begin
        sram_dq_i = 16'hDEAD;
      end
    end
  end

  // issue one request and follow it to completion
  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] sel, input bit spam, input string tag);
    int k;
    int k_rsp;
    int n_rsp;
    int ce_before;
    int exp_lat;
    logic [15:0] got;
    logic [15:0] exp;
    while (!req_ready) @(negedge clk);
    ce_before = ce_cycles;
    exp = lanes_only(ref_get(a), sel);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = sel;
    @(negedge clk);
    if (spam) begin
      req_write = 1'b1; req_addr = a; req_wdata = 16'hBAD0; req_be = 2'b11;
    end else begin
      req_valid = 1'b0;
    end
    if (wr) refm[int'(a)] = merge(ref_get(a), d, sel);
    k = 0; k_rsp = -1; n_rsp = 0; got = '0;
    while (!req_ready && k < 60) begin
      if (rsp_valid) begin n_rsp++; if (k_rsp < 0) k_rsp = k; got = rsp_data; end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    if (rsp_valid) begin n_rsp++; if (k_rsp < 0) k_rsp = k; got = rsp_data; end

    if (sel == 2'b00) exp_lat = 1;
    else if (wr)      exp_lat = EXP_WR + 2;
    else              exp_lat = EXP_RD + EXP_TURN;
    check(k == exp_lat, {tag, " R2/R8 busy length"}, 32'(k), 32'(exp_lat));

    if (wr) begin
      check(n_rsp == 0, {tag, " R2 no response on write"}, 32'(n_rsp), 32'd0);
    end else begin
      check(n_rsp == 1, {tag, " R7 single response pulse"}, 32'(n_rsp), 32'd1);
      check(k_rsp == ((sel == 2'b00) ? 1 : EXP_RD), {tag, " R6 access length to response"},
            32'(k_rsp), 32'((sel == 2'b00) ? 1 : EXP_RD));
      check(got == exp, {tag, " R7 read data"}, 32'(got), 32'(exp));
    end
    if (sel == 2'b00)
      check(ce_cycles == ce_before, {tag, " R9 empty mask strobes nothing"},
            32'(ce_cycles - ce_before), 32'd0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 32'd0, 32'd1);
      report();
      $finish;
    end
  end

  logic [15:0] pool [8];

  initial begin
    void'($urandom(32'd20240611));
    pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h0001; pool[3] = 16'h8000;
    pool[4] = 16'h1234; pool[5] = 16'h00FF; pool[6] = 16'h7FFE; pool[7] = 16'hC0DE;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n} == 5'b11111, "R1 strobes high",
          32'({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}), 32'h1F);
    check(!sram_dq_oe && !rsp_valid, "R1 bus released, no response",
          32'({sram_dq_oe, rsp_valid}), 32'd0);

    // R3 R5 R6 R7: full word write then read
    issue(1, 16'h0000, 16'hBEEF, 2'b11, 0, "full write");
    issue(0, 16'h0000, 16'h0000, 2'b11, 0, "full read");
    // R10: low lane only write, then full read
    issue(1, 16'h0000, 16'h55CD, 2'b01, 0, "low lane write");
    issue(0, 16'h0000, 16'h0000, 2'b11, 0, "R10 merge read");
    // R10: high lane only, read low lane only (R7 zero on high)
    issue(1, 16'h0000, 16'hAB77, 2'b10, 0, "high lane write");
    issue(0, 16'h0000, 16'h0000, 2'b01, 0, "R7 low lane read");
    issue(0, 16'h0000, 16'h0000, 2'b10, 0, "R7 high lane read");
    // R9: empty mask write leaves word, empty mask read returns zero
    issue(1, 16'h0000, 16'h1111, 2'b00, 0, "R9 empty write");
    issue(0, 16'h0000, 16'h0000, 2'b11, 0, "R9 read after empty write");
    issue(0, 16'h0000, 16'h0000, 2'b00, 0, "R9 empty read");
    // R2: requests held during busy are ignored
    issue(1, 16'hFFFF, 16'h600D, 2'b11, 1, "R2 write with held request");
    issue(0, 16'hFFFF, 16'h0000, 2'b11, 0, "R2 read back");
    issue(0, 16'h8000, 16'h0000, 2'b11, 1, "R2 read with held request");
    issue(0, 16'h8000, 16'h0000, 2'b11, 0, "R2 unwritten word intact");
    // R8: read immediately followed by write
    issue(0, 16'h1234, 16'h0000, 2'b11, 0, "R8 read before write");
    issue(1, 16'h1234, 16'h4321, 2'b11, 0, "R8 write after read");
    issue(0, 16'h1234, 16'h0000, 2'b11, 0, "R8 read back");

    for (int i = 0; i < 80; i++) begin
      logic [15:0] a;
      logic [1:0]  s;
      a = pool[$urandom_range(7, 0)];
      s = 2'($urandom_range(3, 0));
      if ($urandom_range(9, 0) == 0) s = 2'b00;
      else if (s == 2'b00) s = 2'b11;
      issue(1'($urandom_range(1, 0)), a, 16'($urandom()), s, 0, "random");
    end
    for (int i = 0; i < 8; i++) issue(0, pool[i], 16'h0000, 2'b11, 0, "R10 final sweep");

    done = 1;
    report();
    $finish;
  end

endmodule